// File: doc/BRIEF.md
# Cycle-Countdown Interrupt Timer

This block is an interrupt timer that sits on a CPU bus. Software programs a 15-bit start value through two byte-wide write registers. Once the timer is armed, it counts down by one on every CPU cycle. When the count runs out, it raises an interrupt and stops.

The low byte is held in a staging latch and has no effect on its own. A write to the high byte does four things in one step:

- it supplies the upper seven bits of the value;
- it loads the whole value into the counter;
- it sets or clears the run enable from its top bit;
- it acknowledges any pending interrupt.

When the count expires, the enable clears itself, so the timer is one-shot. Software re-arms it by writing the high byte again.

Address decoding sits outside the block, and so does the polarity of the CPU's interrupt pin. The block takes one-cycle write strobes, the data byte and a per-cycle enable. It drives an active-high interrupt level.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the interrupt output is low, the timer is stopped, and both the counter and the low-byte latch are zero. A high-byte write of 0x80 with no prior low write therefore loads the value 0.
- R2: A low-byte write only updates the latch. It neither starts the timer nor changes the interrupt output.
- R3: A high-byte write loads the counter with {data[6:0], latch}. If data bit 7 is 1, the interrupt rises after exactly value+1 counting cycles. The 0x7FFF case takes 32768 cycles.
- R4: Data bit 7 of a high-byte write is the run enable. When it is 0, the counter loads but never counts, and the interrupt stays low.
- R5: The counter advances only in cycles where cyc_en is high. Cycles with cyc_en low do not delay or advance expiry other than by being skipped.
- R6: On expiry the interrupt stays high until the next high-byte write. The timer halts with its enable cleared and does not restart on its own.
- R7: Any high-byte write drops the interrupt in the following cycle, whatever the value of its bit 7.
- R8: A high-byte write while the timer is running reloads the counter and restarts the countdown from the new value.
- R9: The latch keeps its value across high-byte writes. When a low-byte and a high-byte write arrive in the same cycle, the commit uses the latch value from before that cycle.
- R10: In a cycle that has both a high-byte write and cyc_en, the write wins and no decrement is applied to the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe (commit, arm, acknowledge) |
| wdata | input | 8 | Write data byte |
| cyc_en | input | 1 | One pulse per CPU cycle; the counter steps when high |
| irq | output | 1 | Active-high interrupt level |

## Verification
A high-byte write commits on the clock edge that samples it. If the value V is armed and cyc_en is held high, the counter reaches zero V edges later and the interrupt rises one edge after that. An acknowledge is visible one edge after its write.

The bench drives every input at the falling edge. After each write it counts rising edges and samples the interrupt at the next falling edge. It checks the level both one cycle before the due edge and on it, so an off-by-one in either direction is caught. Gaps in cyc_en are added to that count one for one.

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cyc_en,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam int EN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] lo_hold;
  logic [CNT_W-1:0]  count;
  logic              run;
  logic              irq_q;

  wire tick    = run && cyc_en && !wr_hi;
  wire expires = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) lo_hold <= '0;
    else if (wr_lo) lo_hold <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      run   <= 1'b0;
      irq_q <= 1'b0;
    end else if (wr_hi) begin
      count <= {wdata[HI_W-1:0], lo_hold};
      run   <= wdata[EN_BIT];
      irq_q <= 1'b0;
    end else if (expires) begin
      run   <= 1'b0;
      irq_q <= 1'b1;
    end else if (tick) begin
      count <= count - CNT_W'(1);
    end
  end

  assign irq = irq_q;

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> !irq);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_hi) |=> irq);

  // R6
  halt_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !run);

  // R2
  lo_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !run) |=> ($stable(count) && !$rose(run)));

  // R5
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !wr_hi) |=> ($stable(count) && $stable(irq)));

  // R3
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run && cyc_en && count == '0));
endmodule

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_lo = 1'b0;
  logic wr_hi = 1'b0;
  logic [7:0] wdata = '0;
  logic cyc_en = 1'b1;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  cyc_irq_timer dut (.clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
                     .wdata(wdata), .cyc_en(cyc_en), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    wr_lo = !hi; wr_hi = hi; wdata = d;
    step(1);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic arm(input logic [14:0] v);
    wr(1'b0, v[7:0]);
    wr(1'b1, {1'b1, v[14:8]});
  endtask

  task automatic t_reset;
    step(2);
    check("R1 reset", 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 after release", 1'b0);
    wr(1'b1, 8'h80);
    check("R1 latch zero, before tick", 1'b0);
    step(1);
    check("R1 value 0 expires after 1 tick", 1'b1);
  endtask

  task automatic t_lo_only;
    wr(1'b1, 8'h00);
    check("R7 ack", 1'b0);
    wr(1'b0, 8'h03);
    step(10);
    check("R2 low write alone", 1'b0);
  endtask

  task automatic t_basic(input logic [14:0] v, input string tag);
    arm(v);
    step(v);
    check(tag, 1'b0);
    step(1);
    check(tag, 1'b1);
    step(20);
    check("R6 irq held", 1'b1);
  endtask

  task automatic t_disabled;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h00);
    check("R7 ack with enable 0", 1'b0);
    step(30);
    check("R4 disabled never fires", 1'b0);
  endtask

  task automatic t_gaps;
    arm(15'd4);
    for (int i = 0; i < 3; i++) begin
      cyc_en = 1'b0; step(2);
      cyc_en = 1'b1; step(1);
    end
    check("R5 3 of 5 ticks", 1'b0);
    cyc_en = 1'b0; step(7);
    check("R5 held while gated", 1'b0);
    cyc_en = 1'b1; step(1);
    check("R5 4th tick", 1'b0);
    step(1);
    check("R5 5th tick expires", 1'b1);
  endtask

  task automatic t_reload;
    arm(15'd10);
    step(6);
    wr(1'b1, 8'h80);
    step(10);
    check("R8 restarted, R9 latch kept", 1'b0);
    step(1);
    check("R8 R9 expiry after reload", 1'b1);
  endtask

  task automatic t_same_cycle;
    wr(1'b0, 8'h03);
    wr_lo = 1'b1; wr_hi = 1'b1; wdata = 8'h80;
    step(1);
    wr_lo = 1'b0; wr_hi = 1'b0;
    step(3);
    check("R9 old latch 3 used", 1'b0);
    step(1);
    check("R9 R10 fires after 4 ticks", 1'b1);
    wr(1'b1, 8'h80);
    step(128);
    check("R9 new latch 0x80 used", 1'b0);
    step(1);
    check("R9 fires at 129 ticks", 1'b1);
  endtask

  task automatic t_no_restart;
    wr(1'b1, 8'h00);
    step(50);
    check("R6 no restart after ack", 1'b0);
  endtask

  initial begin
    t_reset();
    t_lo_only();
    t_basic(15'd5, "R3 value 5");
    t_basic(15'd300, "R3 value 300");
    t_disabled();
    t_gaps();
    t_reload();
    t_same_cycle();
    t_no_restart();
    t_basic(15'h7FFF, "R3 max value");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule